// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block gathers interrupt events from three timers, three external pins with selectable edge, and a detector that watches four port pins for any change. Each event latches a flag. A flag becomes a request only when its own enable bit is set and the global enable bits allow it. The block then raises one of two request lines to the CPU, together with the vector address that the CPU should jump to.

A mode bit selects how the two global enable bits are read. With the mode bit clear, the controller is single-level. One bit is a master enable. The other bit gates only the peripheral sources, which are timers 1 and 2. Every request uses the high line and vector 0x0008. With the mode bit set, the controller is two-level. The first bit enables the high level and the second bit enables the low level. A per-source priority bit chooses the level, and low requests go out on vector 0x0018.

The CPU reports that it took a request by pulsing `ack`. It pulses `reti` when the service routine ends. A small service state machine tracks nesting so that a high request can interrupt a low service in progress. The CPU and its return stack sit outside the block.

Top module: `irq_prio_ctrl`

Service states:
- IDLE: no service is running.
- LO_SVC: a low-level service is running.
- HI_SVC: a high-level service is running and no low service lies underneath it.
- HI_NEST: a high-level service has preempted a low service.

Transitions:
- IDLE goes to HI_SVC when a high request is acknowledged.
- IDLE goes to LO_SVC when a low request is acknowledged.
- LO_SVC goes to HI_NEST when a high request is acknowledged.
- LO_SVC goes to IDLE on `reti`.
- HI_SVC goes to IDLE on `reti`.
- HI_NEST goes back to LO_SVC on `reti`.

## Requirements
- R1: After reset the following are all zero: every flag, every source enable, the control bits, both request lines and all edge history. `vector` reads 0x0008.
- R2: A source event sets that source's flag on the next clock edge, even when the source is disabled. Flag positions are: timer0 bit 0, timer1 bit 1, timer2 bit 2, ext0 bit 3, ext1 bit 4, ext2 bit 5, port change bit 6.
- R3: A flag stays set until software writes a 1 to that bit at the flag register (offset 3). Writing 0 leaves the flag unchanged. If an event and a clear reach the same flag in the same cycle, the flag ends up set.
- R4: External pin k sets its flag on a rising edge when bit k of the edge register (offset 4) is 1. It sets its flag on a falling edge when that bit is 0. The opposite edge has no effect.
- R5: A change of level on any of the four port pins sets the port-change flag.
- R6: Single-level mode applies when control bit 0 (register offset 0) is 0. In this mode `irq_hi` with vector 0x0008 is raised for an enabled pending source only if control bit 1 is set. Timers 1 and 2 also need control bit 2. `irq_lo` is never raised.
- R7: Two-level mode applies when control bit 0 is 1. An enabled pending source with priority bit 1 (register offset 2) raises `irq_hi` with vector 0x0008, gated by control bit 1. One with priority bit 0 raises `irq_lo` with vector 0x0018, gated by control bit 2. When both levels are pending, only `irq_hi` is raised.
- R8: External input 0 is always high level, whatever its priority bit holds.
- R9: Acknowledging a high request clears control bit 1. Acknowledging a low request clears control bit 2. `reti` sets the bit of the level being exited. An `ack` with no request raised, or a `reti` while IDLE, changes nothing.
- R10: During a low service a high request is still raised and can be acknowledged. A low request stays held while any service is active, even if control bit 2 has been set again. Leaving the nested high service returns to the low service.
- R11: Source enables are written at offset 1, one bit per source, using the flag positions. They read back on `enables_o`. Control bits read back on `ctrl_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tmr_evt | input | N_TMR | One-cycle overflow/match pulses from the timers |
| ext_pin | input | N_EXT | External interrupt pin levels |
| port_pin | input | PORT_W | Monitored port pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register offset |
| wr_data | input | NSRC | Register write data |
| ack | input | 1 | CPU has taken the raised request |
| reti | input | 1 | CPU has finished the current service |
| irq_hi | output | 1 | High-level request |
| irq_lo | output | 1 | Low-level request |
| vector | output | VEC_W | Service entry address for the raised request |
| flags_o | output | NSRC | Flag state |
| enables_o | output | NSRC | Source enable state |
| ctrl_o | output | 3 | Mode, high/global enable and low/peripheral enable |

## Verification
The bench fires a timer event and a flag clear in the same cycle. A design that lets the clear win would lose that event.

It drives each external pin through both of its edges. A design with the edge selection inverted would flag the wrong edge.

In single-level mode it raises a peripheral source with only the master bit set. A design that ignores the peripheral gate would raise a request there.

The bench also runs the nesting sequence: low acknowledge, preempting high, nested return, re-enabling the low level during the low service, and the final return. A design without a service state would raise the low request too early. A design that restores the wrong enable on return would raise or hold the wrong line.

// File: rtl/irq_pkg.sv
package irq_pkg;

    // Service state of the CPU as seen by the controller
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LO_SVC  = 2'd1,
        ST_HI_SVC  = 2'd2,
        ST_HI_NEST = 2'd3
    } svc_state_e;

    // Register offsets on the write port
    localparam logic [2:0] REG_CTRL   = 3'd0;
    localparam logic [2:0] REG_ENABLE = 3'd1;
    localparam logic [2:0] REG_PRIO   = 3'd2;
    localparam logic [2:0] REG_FLAG   = 3'd3;
    localparam logic [2:0] REG_EDGE   = 3'd4;

    // Control bit positions
    localparam int CTL_MODE = 0;
    localparam int CTL_GEH  = 1;
    localparam int CTL_GEL  = 2;

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
    parameter int N_EXT  = 3,
    parameter int PORT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_EXT-1:0]  ext_pin,
    input  logic [PORT_W-1:0] port_pin,
    input  logic [N_EXT-1:0]  edge_sel,
    output logic [N_EXT-1:0]  ext_evt,
    output logic              port_evt
);

    logic [N_EXT-1:0]  ext_q;
    logic [PORT_W-1:0] port_q;
    logic              armed_q;

    // History registers; armed_q blocks a false edge on the first cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q   <= '0;
            port_q  <= '0;
            armed_q <= 1'b0;
        end else begin
            ext_q   <= ext_pin;
            port_q  <= port_pin;
            armed_q <= 1'b1;
        end
    end

    for (genvar g = 0; g < N_EXT; g++) begin : g_ext
        logic rise_w;
        logic fall_w;
        assign rise_w     = ext_pin[g] & ~ext_q[g];
        assign fall_w     = ~ext_pin[g] & ext_q[g];
        assign ext_evt[g] = armed_q & (edge_sel[g] ? rise_w : fall_w);
    end

    assign port_evt = armed_q & (|(port_pin ^ port_q));

endmodule

// File: rtl/irq_src_regs.sv
module irq_src_regs
    import irq_pkg::*;
#(
    parameter int NSRC    = 7,
    parameter int N_EXT   = 3,
    parameter int EXT0_IDX = 3,
    parameter int ADDR_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NSRC-1:0]   wr_data,
    input  logic [NSRC-1:0]   src_evt,
    output logic [NSRC-1:0]   flags,
    output logic [NSRC-1:0]   enables,
    output logic [NSRC-1:0]   prio_eff,
    output logic [N_EXT-1:0]  edge_sel
);

    localparam logic [NSRC-1:0] FORCE_HI = {{(NSRC-1){1'b0}}, 1'b1} << EXT0_IDX;

    logic [NSRC-1:0] prio_q;
    logic [NSRC-1:0] clr_mask;
    logic            hit_en, hit_prio, hit_flag, hit_edge;

    assign hit_en   = wr_en && (wr_addr == ADDR_W'(REG_ENABLE));
    assign hit_prio = wr_en && (wr_addr == ADDR_W'(REG_PRIO));
    assign hit_flag = wr_en && (wr_addr == ADDR_W'(REG_FLAG));
    assign hit_edge = wr_en && (wr_addr == ADDR_W'(REG_EDGE));
    assign clr_mask = hit_flag ? wr_data : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags    <= '0;
            enables  <= '0;
            prio_q   <= '0;
            edge_sel <= '0;
        end else begin
            // event wins over a clear in the same cycle
            flags <= (flags & ~clr_mask) | src_evt;
            if (hit_en)   enables  <= wr_data;
            if (hit_prio) prio_q   <= wr_data;
            if (hit_edge) edge_sel <= wr_data[N_EXT-1:0];
        end
    end

    assign prio_eff = prio_q | FORCE_HI;

endmodule

// File: rtl/irq_level_fsm.sv
module irq_level_fsm
    import irq_pkg::*;
#(
    parameter int                NSRC   = 7,
    parameter int                ADDR_W = 3,
    parameter int                VEC_W  = 16,
    parameter logic [VEC_W-1:0]  HI_VEC = 'h0008,
    parameter logic [VEC_W-1:0]  LO_VEC = 'h0018
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [2:0]        wr_ctl,
    input  logic [NSRC-1:0]   pend,
    input  logic [NSRC-1:0]   prio,
    input  logic [NSRC-1:0]   periph,
    input  logic              ack,
    input  logic              reti,
    output logic              irq_hi,
    output logic              irq_lo,
    output logic [VEC_W-1:0]  vector,
    output logic [2:0]        ctrl_o
);

    svc_state_e st_q, st_nxt;
    logic mode_q, geh_q, gel_q;
    logic mode_nxt, geh_nxt, gel_nxt;
    logic hi_src, lo_src, hi_allowed, take_hi, take_lo;

    // ---- output process ----
    always_comb begin
        if (mode_q) begin
            hi_src = |(pend & prio);
            lo_src = |(pend & ~prio);
        end else begin
            hi_src = (|(pend & ~periph)) | (gel_q & (|(pend & periph)));
            lo_src = 1'b0;
        end
        hi_allowed = (st_q == ST_IDLE) || (st_q == ST_LO_SVC);
        irq_hi = geh_q & hi_src & hi_allowed;
        irq_lo = mode_q & gel_q & lo_src & (st_q == ST_IDLE) & ~irq_hi;
        vector = irq_lo ? LO_VEC : HI_VEC;
        ctrl_o = {gel_q, geh_q, mode_q};
    end

    // ---- next-state logic ----
    always_comb begin
        st_nxt   = st_q;
        mode_nxt = mode_q;
        geh_nxt  = geh_q;
        gel_nxt  = gel_q;
        take_hi  = ack & irq_hi;
        take_lo  = ack & irq_lo;
        unique case (st_q)
            ST_IDLE: begin
                if (take_hi) begin
                    st_nxt  = ST_HI_SVC;
                    geh_nxt = 1'b0;
                end else if (take_lo) begin
                    st_nxt  = ST_LO_SVC;
                    gel_nxt = 1'b0;
                end
            end
            ST_LO_SVC: begin
                if (take_hi) begin
                    st_nxt  = ST_HI_NEST;
                    geh_nxt = 1'b0;
                end else if (reti) begin
                    st_nxt  = ST_IDLE;
                    gel_nxt = 1'b1;
                end
            end
            ST_HI_SVC: begin
                if (reti) begin
                    st_nxt  = ST_IDLE;
                    geh_nxt = 1'b1;
                end
            end
            ST_HI_NEST: begin
                if (reti) begin
                    st_nxt  = ST_LO_SVC;
                    geh_nxt = 1'b1;
                end
            end
        endcase
        if (wr_en && (wr_addr == ADDR_W'(REG_CTRL))) begin
            mode_nxt = wr_ctl[CTL_MODE];
            geh_nxt  = wr_ctl[CTL_GEH];
            gel_nxt  = wr_ctl[CTL_GEL];
        end
    end

    // ---- state register ----
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            mode_q <= 1'b0;
            geh_q  <= 1'b0;
            gel_q  <= 1'b0;
        end else begin
            st_q   <= st_nxt;
            mode_q <= mode_nxt;
            geh_q  <= geh_nxt;
            gel_q  <= gel_nxt;
        end
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter int               N_TMR  = 3,
    parameter int               N_EXT  = 3,
    parameter int               PORT_W = 4,
    parameter int               ADDR_W = 3,
    parameter int               VEC_W  = 16,
    parameter logic [VEC_W-1:0] HI_VEC = 'h0008,
    parameter logic [VEC_W-1:0] LO_VEC = 'h0018,
    localparam int              NSRC   = N_TMR + N_EXT + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_TMR-1:0]  tmr_evt,
    input  logic [N_EXT-1:0]  ext_pin,
    input  logic [PORT_W-1:0] port_pin,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NSRC-1:0]   wr_data,
    input  logic              ack,
    input  logic              reti,
    output logic              irq_hi,
    output logic              irq_lo,
    output logic [VEC_W-1:0]  vector,
    output logic [NSRC-1:0]   flags_o,
    output logic [NSRC-1:0]   enables_o,
    output logic [2:0]        ctrl_o
);

    localparam int EXT0_IDX = N_TMR;

    logic [N_EXT-1:0] edge_sel;
    logic [N_EXT-1:0] ext_evt;
    logic             port_evt;
    logic [NSRC-1:0]  src_evt;
    logic [NSRC-1:0]  prio_eff;
    logic [NSRC-1:0]  periph_mask;
    logic [NSRC-1:0]  pend;

    // timers other than timer0 count as peripheral sources
    for (genvar i = 0; i < NSRC; i++) begin : g_periph
        assign periph_mask[i] = (i >= 1) && (i < N_TMR);
    end

    irq_edge_detect #(.N_EXT(N_EXT), .PORT_W(PORT_W)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_pin  (ext_pin),
        .port_pin (port_pin),
        .edge_sel (edge_sel),
        .ext_evt  (ext_evt),
        .port_evt (port_evt)
    );

    assign src_evt = {port_evt, ext_evt, tmr_evt};

    irq_src_regs #(
        .NSRC(NSRC), .N_EXT(N_EXT), .EXT0_IDX(EXT0_IDX), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .src_evt  (src_evt),
        .flags    (flags_o),
        .enables  (enables_o),
        .prio_eff (prio_eff),
        .edge_sel (edge_sel)
    );

    assign pend = flags_o & enables_o;

    irq_level_fsm #(
        .NSRC(NSRC), .ADDR_W(ADDR_W), .VEC_W(VEC_W),
        .HI_VEC(HI_VEC), .LO_VEC(LO_VEC)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_ctl  (wr_data[2:0]),
        .pend    (pend),
        .prio    (prio_eff),
        .periph  (periph_mask),
        .ack     (ack),
        .reti    (reti),
        .irq_hi  (irq_hi),
        .irq_lo  (irq_lo),
        .vector  (vector),
        .ctrl_o  (ctrl_o)
    );

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
    import irq_pkg::*;
#(
    parameter int               NSRC   = 7,
    parameter int               N_TMR  = 3,
    parameter int               ADDR_W = 3,
    parameter int               VEC_W  = 16,
    parameter logic [VEC_W-1:0] HI_VEC = 'h0008,
    parameter logic [VEC_W-1:0] LO_VEC = 'h0018
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_TMR-1:0]  tmr_evt,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [NSRC-1:0]   wr_data,
    input logic              ack,
    input logic              irq_hi,
    input logic              irq_lo,
    input logic [VEC_W-1:0]  vector,
    input logic [NSRC-1:0]   flags_o,
    input logic [2:0]        ctrl_o
);

    logic            ctrl_wr;
    logic [NSRC-1:0] keep;
    assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(REG_CTRL));
    assign keep    = flags_o & ~((wr_en && (wr_addr == ADDR_W'(REG_FLAG))) ? wr_data : '0);

    // R7
    one_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_hi && irq_lo));

    // R6
    legacy_no_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_o[CTL_MODE] |-> !irq_lo);

    // R7
    lo_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lo |-> (vector == LO_VEC));

    // R6
    hi_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hi |-> (vector == HI_VEC));

    // R9
    ack_hi_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_hi && !ctrl_wr) |=> !ctrl_o[CTL_GEH]);

    // R9
    ack_lo_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_lo && !ctrl_wr) |=> !ctrl_o[CTL_GEL]);

    // R2
    tmr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_evt[0] |=> flags_o[0]);

    // R3
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_o & $past(keep)) == $past(keep)));

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
    .NSRC(NSRC), .N_TMR(N_TMR), .ADDR_W(ADDR_W), .VEC_W(VEC_W),
    .HI_VEC(HI_VEC), .LO_VEC(LO_VEC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tmr_evt(tmr_evt), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .ack(ack), .irq_hi(irq_hi),
    .irq_lo(irq_lo), .vector(vector), .flags_o(flags_o), .ctrl_o(ctrl_o)
);

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/1ps
module test_irq_prio_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  tmr_evt;
    logic [2:0]  ext_pin;
    logic [3:0]  port_pin;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [6:0]  wr_data;
    logic        ack, reti;
    logic        irq_hi, irq_lo;
    logic [15:0] vector;
    logic [6:0]  flags_o, enables_o;
    logic [2:0]  ctrl_o;

    always #4 clk = ~clk;

    irq_prio_ctrl i_irq_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .tmr_evt(tmr_evt), .ext_pin(ext_pin),
        .port_pin(port_pin), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ack(ack), .reti(reti), .irq_hi(irq_hi), .irq_lo(irq_lo), .vector(vector),
        .flags_o(flags_o), .enables_o(enables_o), .ctrl_o(ctrl_o)
    );

    typedef struct {
        string       tag;
        logic        hi;
        logic        lo;
        logic [15:0] vec;
        logic [6:0]  fl;
        logic [6:0]  en;
        logic [2:0]  ct;
    } exp_t;

    exp_t sb_q[$];
    int   n_vec  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    // ---- monitor: compare at the falling edge ----
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_vec++;
                if (irq_hi !== e.hi || irq_lo !== e.lo || vector !== e.vec ||
                    flags_o !== e.fl || enables_o !== e.en || ctrl_o !== e.ct) begin
                    n_fail++;
                    $display("FAIL %s: got hi=%b lo=%b vec=%h fl=%h en=%h ct=%h, want hi=%b lo=%b vec=%h fl=%h en=%h ct=%h",
                             e.tag, irq_hi, irq_lo, vector, flags_o, enables_o, ctrl_o,
                             e.hi, e.lo, e.vec, e.fl, e.en, e.ct);
                end
            end
        end
    end

    // ---- driver helpers ----
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_(input string tag, input logic hi, input logic lo,
                           input logic [15:0] vec, input logic [6:0] fl,
                           input logic [6:0] en, input logic [2:0] ct);
        exp_t e;
        e.tag = tag; e.hi = hi; e.lo = lo; e.vec = vec;
        e.fl = fl; e.en = en; e.ct = ct;
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [6:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic pulse_tmr(input int i);
        tmr_evt[i] = 1'b1;
        step();
        tmr_evt = '0;
    endtask

    task automatic set_ext(input int i, input logic v);
        ext_pin[i] = v;
        step();
    endtask

    task automatic do_ack();
        ack = 1'b1; step(); ack = 1'b0;
    endtask

    task automatic do_reti();
        reti = 1'b1; step(); reti = 1'b0;
    endtask

    localparam logic [2:0] A_CTRL = 3'd0, A_EN = 3'd1, A_PRIO = 3'd2,
                           A_FLAG = 3'd3, A_EDGE = 3'd4;
    localparam logic [15:0] VH = 16'h0008, VL = 16'h0018;

    // ---- watchdog ----
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    // ---- stimulus ----
    initial begin
        rst_n = 1'b0; tmr_evt = '0; ext_pin = '0; port_pin = '0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0; ack = 1'b0; reti = 1'b0;
        repeat (3) step();
        expect_("R1 reset state", 0, 0, VH, 7'h00, 7'h00, 3'b000);
        rst_n = 1'b1;
        step(); step();
        expect_("R1 after release", 0, 0, VH, 7'h00, 7'h00, 3'b000);

        // R2: flag while disabled
        pulse_tmr(0);
        expect_("R2 disabled timer0 flag", 0, 0, VH, 7'h01, 7'h00, 3'b000);
        // R3: write-one-to-clear
        wr(A_FLAG, 7'h00);
        expect_("R3 zero write keeps", 0, 0, VH, 7'h01, 7'h00, 3'b000);
        wr(A_FLAG, 7'h01);
        expect_("R3 one write clears", 0, 0, VH, 7'h00, 7'h00, 3'b000);
        tmr_evt[1] = 1'b1;
        wr(A_FLAG, 7'h02);
        tmr_evt = '0;
        expect_("R3 set beats clear", 0, 0, VH, 7'h02, 7'h00, 3'b000);
        wr(A_FLAG, 7'h7F);

        // R4: edge selection
        wr(A_EDGE, 7'h02);
        set_ext(0, 1'b1);
        expect_("R4 ext0 wrong edge", 0, 0, VH, 7'h00, 7'h00, 3'b000);
        set_ext(0, 1'b0);
        expect_("R4 ext0 falling", 0, 0, VH, 7'h08, 7'h00, 3'b000);
        set_ext(1, 1'b1);
        expect_("R4 ext1 rising", 0, 0, VH, 7'h18, 7'h00, 3'b000);
        set_ext(2, 1'b1);
        expect_("R4 ext2 wrong edge", 0, 0, VH, 7'h18, 7'h00, 3'b000);
        wr(A_FLAG, 7'h7F);
        set_ext(2, 1'b0);
        expect_("R4 ext2 falling", 0, 0, VH, 7'h20, 7'h00, 3'b000);
        set_ext(1, 1'b0);
        expect_("R4 ext1 falling ignored", 0, 0, VH, 7'h20, 7'h00, 3'b000);
        wr(A_FLAG, 7'h7F);

        // R5: port change
        port_pin = 4'b0100; step();
        expect_("R5 one pin rises", 0, 0, VH, 7'h40, 7'h00, 3'b000);
        wr(A_FLAG, 7'h40);
        port_pin = 4'b0000; step();
        expect_("R5 pin falls", 0, 0, VH, 7'h40, 7'h00, 3'b000);
        wr(A_FLAG, 7'h40);
        port_pin = 4'b1001; step();
        expect_("R5 two pins change", 0, 0, VH, 7'h40, 7'h00, 3'b000);
        port_pin = 4'b1001; step();
        wr(A_FLAG, 7'h7F);
        expect_("R5 steady pins", 0, 0, VH, 7'h00, 7'h00, 3'b000);

        // R6: single-level mode
        wr(A_EN, 7'h7F);
        expect_("R11 enables readback", 0, 0, VH, 7'h00, 7'h7F, 3'b000);
        pulse_tmr(0);
        expect_("R6 master off", 0, 0, VH, 7'h01, 7'h7F, 3'b000);
        wr(A_CTRL, 3'b010);
        expect_("R6 master on", 1, 0, VH, 7'h01, 7'h7F, 3'b010);
        wr(A_FLAG, 7'h01);
        pulse_tmr(1);
        expect_("R6 peripheral gated", 0, 0, VH, 7'h02, 7'h7F, 3'b010);
        wr(A_CTRL, 3'b110);
        expect_("R6 peripheral on", 1, 0, VH, 7'h02, 7'h7F, 3'b110);

        // R9: acknowledge and return in single-level mode
        do_ack();
        expect_("R9 ack clears master", 0, 0, VH, 7'h02, 7'h7F, 3'b100);
        wr(A_FLAG, 7'h02);
        do_reti();
        expect_("R9 reti restores master", 0, 0, VH, 7'h00, 7'h7F, 3'b110);

        // R7: two-level mode
        wr(A_CTRL, 3'b111);
        wr(A_PRIO, 7'h01);
        pulse_tmr(1);
        expect_("R7 low request", 0, 1, VL, 7'h02, 7'h7F, 3'b111);
        pulse_tmr(0);
        expect_("R7 high wins", 1, 0, VH, 7'h03, 7'h7F, 3'b111);
        wr(A_FLAG, 7'h01);
        expect_("R7 low again", 0, 1, VL, 7'h02, 7'h7F, 3'b111);
        wr(A_CTRL, 3'b011);
        expect_("R7 low level disabled", 0, 0, VH, 7'h02, 7'h7F, 3'b011);
        wr(A_CTRL, 3'b111);

        // R9/R10: nesting
        do_ack();
        expect_("R9 ack low clears low enable", 0, 0, VH, 7'h02, 7'h7F, 3'b011);
        pulse_tmr(0);
        expect_("R10 high preempts low", 1, 0, VH, 7'h03, 7'h7F, 3'b011);
        do_ack();
        expect_("R9 ack high clears high enable", 0, 0, VH, 7'h03, 7'h7F, 3'b001);
        wr(A_FLAG, 7'h01);
        do_reti();
        expect_("R10 nested return", 0, 0, VH, 7'h02, 7'h7F, 3'b011);
        wr(A_CTRL, 3'b111);
        expect_("R10 low held in service", 0, 0, VH, 7'h02, 7'h7F, 3'b111);
        do_reti();
        expect_("R10 low after service ends", 0, 1, VL, 7'h02, 7'h7F, 3'b111);

        // R9: ignored strobes
        wr(A_FLAG, 7'h02);
        do_ack();
        expect_("R9 stray ack", 0, 0, VH, 7'h00, 7'h7F, 3'b111);
        do_reti();
        expect_("R9 stray reti", 0, 0, VH, 7'h00, 7'h7F, 3'b111);

        // R8: ext0 always high level
        wr(A_PRIO, 7'h00);
        wr(A_EDGE, 7'h01);
        set_ext(0, 1'b1);
        expect_("R8 ext0 forced high", 1, 0, VH, 7'h08, 7'h7F, 3'b111);
        wr(A_FLAG, 7'h08);
        set_ext(1, 1'b1);
        set_ext(1, 1'b0);
        expect_("R8 ext1 follows priority", 0, 1, VL, 7'h10, 7'h7F, 3'b111);
        wr(A_FLAG, 7'h7F);

        // R2: disabled source sets flag without request
        wr(A_EN, 7'h00);
        pulse_tmr(2);
        expect_("R2 disabled no request", 0, 0, VH, 7'h04, 7'h00, 3'b111);

        step();
        @(negedge clk);
        #1;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule